// File: doc/BRIEF.md
# Two-Wire Register Front End for an LED Dimmer

This block is the serial slave side of a small LED-dimming controller. It watches an oversampled two-wire bus (clock and open-drain data). It recognises start and stop conditions and answers only its own 7-bit device address. The upper four address bits are fixed and the lower three come from strap inputs, so eight such blocks can share one bus. The first byte written after the address is a command byte. Its three low bits form a register pointer, and bit 4 switches on automatic pointer stepping. Later bytes of the same write go to the register the pointer selects. A read started with a repeated start returns registers from that pointer onward.

Six writable registers drive the dimming logic: two period prescalers, two duty values and two 8-bit selector words. They appear as parallel outputs. Pointer value 0 selects a read-only view of the live output pin levels.

Top module: `led_dimmer_i2c`

## Requirements
- R1: After reset, rate0, duty0, rate1, sel_lo and sel_hi are 00h, duty1 is 80h, and sda_oe is 0 (data line released).
- R2: The block acknowledges only an address byte whose upper seven bits equal {1100b, dev_sel[2:0]}. Any other address gets no acknowledge, and the bytes that follow it up to the next start are neither acknowledged nor stored.
- R3: The command byte's bits [2:0] select the register: 1 rate0, 2 duty0, 3 rate1, 4 duty1, 5 sel_lo, 6 sel_hi, 7 also sel_hi. A data byte written after the command updates that register's output.
- R4: When command bit 4 is 1, the pointer steps by one after every data byte written or read, and goes 6, 7, 0. When bit 4 is 0, the pointer stays put, so repeated bytes hit the same register.
- R5: A data byte written while the pointer is 0 is acknowledged and changes no register.
- R6: A read while the pointer is 0 returns pin_levels as sampled when that byte starts.
- R7: Read data leaves most significant bit first. After the master sends no acknowledge (data high in the ninth slot), the block releases the data line and sends nothing more until the next start. sda_oe changes only while the clock is low.
- R8: A repeated start, with no stop before it, restarts address reception and keeps the pointer. This is how the block switches from writing the command byte to reading.
- R9: The block pulls the data line low in the ninth clock slot after each accepted address, command or write-data byte. It never drives the line while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_sel | input | 3 | Low three bits of the device address |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe | output | 1 | 1 pulls the data line low |
| pin_levels | input | 8 | Live levels of the eight output pins |
| rate0 | output | 8 | Period prescaler for blink source 0 |
| duty0 | output | 8 | Duty value for blink source 0 |
| rate1 | output | 8 | Period prescaler for blink source 1 |
| duty1 | output | 8 | Duty value for blink source 1 |
| sel_lo | output | 8 | Source selectors for pins 0 to 3 |
| sel_hi | output | 8 | Source selectors for pins 4 to 7 |

## Verification
The hardest state to reach from the ports is a pointer that wraps through the aliased value 7 into the pin view in the middle of one read burst. It takes a command byte with the stepping flag set and a start pointer of 5, then a repeated start into a read where the master acknowledges three bytes and refuses the fourth. The bench changes pin_levels just before that burst, so the last byte can only match if it came from the live pins. The expected sequence sel_lo, sel_hi, sel_hi, pins checks the 6, 7, 0 order directly.

// File: rtl/li2c_pkg.sv
package li2c_pkg;

    localparam int DATA_W = 8;
    localparam int PTR_W  = 3;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_ADDR,
        LK_CTRL,
        LK_WDAT,
        LK_RDAT,
        LK_WAIT
    } link_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] rate0;
        logic [DATA_W-1:0] duty0;
        logic [DATA_W-1:0] rate1;
        logic [DATA_W-1:0] duty1;
        logic [DATA_W-1:0] sel_lo;
        logic [DATA_W-1:0] sel_hi;
    } dim_regs_t;

    localparam dim_regs_t REGS_RESET = '{
        rate0:  8'h00,
        duty0:  8'h00,
        rate1:  8'h00,
        duty1:  8'h80,
        sel_lo: 8'h00,
        sel_hi: 8'h00
    };

    localparam logic [PTR_W-1:0] IDX_PINS  = 3'd0;
    localparam logic [PTR_W-1:0] IDX_RATE0 = 3'd1;
    localparam logic [PTR_W-1:0] IDX_DUTY0 = 3'd2;
    localparam logic [PTR_W-1:0] IDX_RATE1 = 3'd3;
    localparam logic [PTR_W-1:0] IDX_DUTY1 = 3'd4;
    localparam logic [PTR_W-1:0] IDX_SELLO = 3'd5;
    localparam logic [PTR_W-1:0] IDX_SELHI = 3'd6;

    localparam int CMD_AUTO_BIT = 4;

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
        return p + 3'd1;
    endfunction

    function automatic logic [DATA_W-1:0] reg_pick(
        input dim_regs_t         r,
        input logic [DATA_W-1:0] pins,
        input logic [PTR_W-1:0]  idx
    );
        case (idx)
            IDX_PINS:  return pins;
            IDX_RATE0: return r.rate0;
            IDX_DUTY0: return r.duty0;
            IDX_RATE1: return r.rate1;
            IDX_DUTY1: return r.duty1;
            IDX_SELLO: return r.sel_lo;
            default:   return r.sel_hi;
        endcase
    endfunction

endpackage

// File: rtl/li2c_line_sync.sv
module li2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int PIPE_W = (STAGES < 2) ? 2 : STAGES;

    logic [PIPE_W-1:0] scl_pipe;
    logic [PIPE_W-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_i};
            sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_i};
            scl_d    <= scl_pipe[PIPE_W-1];
            sda_d    <= sda_pipe[PIPE_W-1];
        end
    end

    assign scl_s     = scl_pipe[PIPE_W-1];
    assign sda_s     = sda_pipe[PIPE_W-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/li2c_link.sv
module li2c_link
    import li2c_pkg::*;
#(
    parameter logic [3:0] DEV_ID = 4'b1100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        dev_sel,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [DATA_W-1:0] rd_data,
    output logic [PTR_W-1:0]  ptr,
    output logic              auto_inc,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              sda_oe,
    output logic              link_idle,
    output logic              byte_end
);

    link_state_e       state_q;
    logic [3:0]        bit_cnt_q;
    logic              ack_ph_q;
    logic [DATA_W-1:0] shreg_q;
    logic [DATA_W-1:0] tx_q;
    logic              rw_q;
    logic              mack_q;
    logic [PTR_W-1:0]  ptr_q;
    logic              ai_q;
    logic              oe_q;
    logic              wr_en_q;
    logic [PTR_W-1:0]  wr_idx_q;
    logic [DATA_W-1:0] wr_data_q;
    logic              full_byte;
    logic              addr_hit;

    assign full_byte = (bit_cnt_q == 4'd8) && !ack_ph_q;
    assign addr_hit  = (shreg_q[7:1] == {DEV_ID, dev_sel});
    assign byte_end  = scl_fall && !start_det && !stop_det && full_byte &&
                       ((state_q == LK_WDAT) || (state_q == LK_RDAT));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= LK_IDLE;
            bit_cnt_q <= '0;
            ack_ph_q  <= 1'b0;
            shreg_q   <= '0;
            tx_q      <= '0;
            rw_q      <= 1'b0;
            mack_q    <= 1'b1;
            ptr_q     <= '0;
            ai_q      <= 1'b0;
            oe_q      <= 1'b0;
            wr_en_q   <= 1'b0;
            wr_idx_q  <= '0;
            wr_data_q <= '0;
        end else begin
            wr_en_q <= 1'b0;
            if (start_det) begin
                state_q   <= LK_ADDR;
                bit_cnt_q <= '0;
                ack_ph_q  <= 1'b0;
                oe_q      <= 1'b0;
            end else if (stop_det) begin
                state_q  <= LK_IDLE;
                ack_ph_q <= 1'b0;
                oe_q     <= 1'b0;
            end else if (scl_rise) begin
                case (state_q)
                    LK_ADDR, LK_CTRL, LK_WDAT: begin
                        if (!ack_ph_q) begin
                            shreg_q   <= {shreg_q[DATA_W-2:0], sda_s};
                            bit_cnt_q <= bit_cnt_q + 4'd1;
                        end
                    end
                    LK_RDAT: begin
                        if (ack_ph_q) mack_q <= sda_s;
                        else          bit_cnt_q <= bit_cnt_q + 4'd1;
                    end
                    default: ;
                endcase
            end else if (scl_fall) begin
                case (state_q)
                    LK_ADDR: begin
                        if (ack_ph_q) begin
                            ack_ph_q  <= 1'b0;
                            bit_cnt_q <= '0;
                            if (rw_q) begin
                                state_q <= LK_RDAT;
                                tx_q    <= rd_data;
                                oe_q    <= ~rd_data[DATA_W-1];
                            end else begin
                                state_q <= LK_CTRL;
                                oe_q    <= 1'b0;
                            end
                        end else if (full_byte) begin
                            if (addr_hit) begin
                                ack_ph_q <= 1'b1;
                                oe_q     <= 1'b1;
                                rw_q     <= shreg_q[0];
                            end else begin
                                state_q <= LK_WAIT;
                            end
                        end
                    end
                    LK_CTRL: begin
                        if (ack_ph_q) begin
                            ack_ph_q  <= 1'b0;
                            oe_q      <= 1'b0;
                            bit_cnt_q <= '0;
                            state_q   <= LK_WDAT;
                        end else if (full_byte) begin
                            ptr_q    <= shreg_q[PTR_W-1:0];
                            ai_q     <= shreg_q[CMD_AUTO_BIT];
                            ack_ph_q <= 1'b1;
                            oe_q     <= 1'b1;
                        end
                    end
                    LK_WDAT: begin
                        if (ack_ph_q) begin
                            ack_ph_q  <= 1'b0;
                            oe_q      <= 1'b0;
                            bit_cnt_q <= '0;
                        end else if (full_byte) begin
                            wr_en_q   <= 1'b1;
                            wr_idx_q  <= ptr_q;
                            wr_data_q <= shreg_q;
                            if (ai_q) ptr_q <= ptr_step(ptr_q);
                            ack_ph_q  <= 1'b1;
                            oe_q      <= 1'b1;
                        end
                    end
                    LK_RDAT: begin
                        if (ack_ph_q) begin
                            ack_ph_q  <= 1'b0;
                            bit_cnt_q <= '0;
                            if (!mack_q) begin
                                tx_q <= rd_data;
                                oe_q <= ~rd_data[DATA_W-1];
                            end else begin
                                state_q <= LK_WAIT;
                                oe_q    <= 1'b0;
                            end
                        end else if (full_byte) begin
                            oe_q     <= 1'b0;
                            ack_ph_q <= 1'b1;
                            if (ai_q) ptr_q <= ptr_step(ptr_q);
                        end else begin
                            oe_q <= ~tx_q[3'd7 - bit_cnt_q[2:0]];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ptr       = ptr_q;
    assign auto_inc  = ai_q;
    assign wr_en     = wr_en_q;
    assign wr_idx    = wr_idx_q;
    assign wr_data   = wr_data_q;
    assign sda_oe    = oe_q;
    assign link_idle = (state_q == LK_IDLE);

endmodule

// File: rtl/li2c_regbank.sv
module li2c_regbank
    import li2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] pins,
    output logic [DATA_W-1:0] rd_data,
    output dim_regs_t         regs
);

    dim_regs_t regs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= REGS_RESET;
        end else if (wr_en) begin
            case (wr_idx)
                IDX_RATE0: regs_q.rate0  <= wr_data;
                IDX_DUTY0: regs_q.duty0  <= wr_data;
                IDX_RATE1: regs_q.rate1  <= wr_data;
                IDX_DUTY1: regs_q.duty1  <= wr_data;
                IDX_SELLO: regs_q.sel_lo <= wr_data;
                IDX_PINS:  ;
                default:   regs_q.sel_hi <= wr_data;
            endcase
        end
    end

    assign rd_data = reg_pick(regs_q, pins, rd_idx);
    assign regs    = regs_q;

endmodule

// File: rtl/led_dimmer_i2c.sv
module led_dimmer_i2c
    import li2c_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_ID      = 4'b1100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        dev_sel,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [DATA_W-1:0] pin_levels,
    output logic [DATA_W-1:0] rate0,
    output logic [DATA_W-1:0] duty0,
    output logic [DATA_W-1:0] rate1,
    output logic [DATA_W-1:0] duty1,
    output logic [DATA_W-1:0] sel_lo,
    output logic [DATA_W-1:0] sel_hi
);

    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic [PTR_W-1:0]  ptr;
    logic              auto_inc;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic              link_idle;
    logic              byte_end;
    dim_regs_t         regs;

    li2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    li2c_link #(.DEV_ID(DEV_ID)) u_link (
        .clk       (clk),
        .rst       (rst),
        .dev_sel   (dev_sel),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .ptr       (ptr),
        .auto_inc  (auto_inc),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe),
        .link_idle (link_idle),
        .byte_end  (byte_end)
    );

    li2c_regbank u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (ptr),
        .pins    (pin_levels),
        .rd_data (rd_data),
        .regs    (regs)
    );

    assign rate0  = regs.rate0;
    assign duty0  = regs.duty0;
    assign rate1  = regs.rate1;
    assign duty1  = regs.duty1;
    assign sel_lo = regs.sel_lo;
    assign sel_hi = regs.sel_hi;

endmodule

// File: rtl/li2c_checker.sv
module li2c_checker
    import li2c_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sda_oe,
    input logic             scl_s,
    input logic             link_idle,
    input logic             byte_end,
    input logic             auto_inc,
    input logic [PTR_W-1:0] ptr,
    input logic             wr_en,
    input logic [PTR_W-1:0] wr_idx,
    input dim_regs_t        regs
);

    AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (regs == REGS_RESET && !sda_oe));  // R1

    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (byte_end && auto_inc) |=> (ptr == 3'($past(ptr) + 3'd1)));  // R4

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (byte_end && !auto_inc) |=> $stable(ptr));  // R4

    AST_PIN_VIEW_INERT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IDX_PINS) |=> $stable(regs));  // R5

    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_s);  // R7

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        link_idle |-> !sda_oe);  // R9

endmodule

bind led_dimmer_i2c li2c_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .sda_oe    (sda_oe),
    .scl_s     (scl_s),
    .link_idle (link_idle),
    .byte_end  (byte_end),
    .auto_inc  (auto_inc),
    .ptr       (ptr),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .regs      (regs)
);

// File: tb/test_led_dimmer_i2c.sv
module test_led_dimmer_i2c;

    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] dev_sel = 3'd0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_oe;
    logic       sda_line;
    logic [7:0] pin_levels = 8'hA5;
    logic [7:0] rate0, duty0, rate1, duty1, sel_lo, sel_hi;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    led_dimmer_i2c i_led_dimmer_i2c (
        .clk        (clk),
        .rst        (rst),
        .dev_sel    (dev_sel),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .sda_oe     (sda_oe),
        .pin_levels (pin_levels),
        .rate0      (rate0),
        .duty0      (duty0),
        .rate1      (rate1),
        .duty1      (duty1),
        .sel_lo     (sel_lo),
        .sel_hi     (sel_hi)
    );

    // {command, write data, expected read-back}
    localparam logic [23:0] VEC [7] = '{
        {8'h01, 8'h97, 8'h97},
        {8'h02, 8'h80, 8'h80},
        {8'h03, 8'h2B, 8'h2B},
        {8'h04, 8'h40, 8'h40},
        {8'h05, 8'h55, 8'h55},
        {8'h06, 8'hFA, 8'hFA},
        {8'h00, 8'h12, 8'hA5}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; w(Q);
        m_scl = 1'b1; w(Q);
        m_sda = 1'b0; w(Q);
        m_scl = 1'b0; w(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; w(Q);
        m_scl = 1'b1; w(Q);
        m_sda = 1'b1; w(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; w(Q);
            m_scl = 1'b1; w(Q);
            m_scl = 1'b0; w(Q);
        end
        m_sda = 1'b1; w(Q);
        m_scl = 1'b1; w(Q / 2);
        acked = (sda_line === 1'b0);
        w(Q / 2);
        m_scl = 1'b0; w(Q);
    endtask

    task automatic put(input logic [7:0] b, input logic exp_ack, input string req);
        logic a;
        send_byte(b, a);
        chk(req, {7'd0, a}, {7'd0, exp_ack});
    endtask

    task automatic read_byte(input logic nack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            w(Q);
            m_scl = 1'b1; w(Q / 2);
            b[i] = sda_line;
            w(Q / 2);
            m_scl = 1'b0;
        end
        w(Q);
        m_sda = nack; w(Q);
        m_scl = 1'b1; w(Q);
        m_scl = 1'b0; w(Q);
        m_sda = 1'b1;
    endtask

    task automatic read_one(input logic [7:0] cmd, input logic [7:0] exp, input string req);
        logic [7:0] got;
        bus_start();
        put(8'hC0, 1'b1, "R9 address ack");
        put(cmd, 1'b1, "R9 command ack");
        bus_start();
        put(8'hC1, 1'b1, "R8 repeated start read address ack");
        read_byte(1'b1, got);
        bus_stop();
        chk(req, got, exp);
    endtask

    function automatic logic [7:0] port_of(input logic [2:0] idx);
        case (idx)
            3'd1:    return rate0;
            3'd2:    return duty0;
            3'd3:    return rate1;
            3'd4:    return duty1;
            3'd5:    return sel_lo;
            default: return sel_hi;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] got;
        w(5);
        rst = 1'b0;
        w(3);

        // R1 reset state
        chk("R1 rate0", rate0, 8'h00);
        chk("R1 duty0", duty0, 8'h00);
        chk("R1 rate1", rate1, 8'h00);
        chk("R1 duty1", duty1, 8'h80);
        chk("R1 sel_lo", sel_lo, 8'h00);
        chk("R1 sel_hi", sel_hi, 8'h00);
        chk("R1 sda released", {7'd0, sda_oe}, 8'h00);

        // R3 / R5 / R6 / R8: single writes then read-back through a repeated start
        for (int k = 0; k < 7; k++) begin
            bus_start();
            put(8'hC0, 1'b1, "R9 address ack");
            put(VEC[k][23:16], 1'b1, "R9 command ack");
            put(VEC[k][15:8], 1'b1, "R5 R9 data ack");
            bus_stop();
            if (VEC[k][18:16] != 3'd0)
                chk("R3 register output", port_of(VEC[k][18:16]), VEC[k][15:8]);
            read_one(VEC[k][23:16], VEC[k][7:0], "R3 R6 read-back");
        end
        // R5: the write to the pin view left every register as set above
        chk("R5 rate0 kept", rate0, 8'h97);
        chk("R5 duty0 kept", duty0, 8'h80);
        chk("R5 rate1 kept", rate1, 8'h2B);
        chk("R5 duty1 kept", duty1, 8'h40);
        chk("R5 sel_lo kept", sel_lo, 8'h55);
        chk("R5 sel_hi kept", sel_hi, 8'hFA);

        // R4 burst write with stepping, start at pointer 1
        bus_start();
        put(8'hC0, 1'b1, "R9 address ack");
        put(8'h11, 1'b1, "R4 command ack");
        for (int k = 1; k <= 5; k++) put(8'(k), 1'b1, "R4 burst data ack");
        bus_stop();
        chk("R4 burst rate0", rate0, 8'h01);
        chk("R4 burst duty0", duty0, 8'h02);
        chk("R4 burst rate1", rate1, 8'h03);
        chk("R4 burst duty1", duty1, 8'h04);
        chk("R4 burst sel_lo", sel_lo, 8'h05);
        chk("R4 burst stops before sel_hi", sel_hi, 8'hFA);

        // R4 / R6 / R7 wrap read 5,6,7,0 with fresh pin levels
        pin_levels = 8'h3C;
        bus_start();
        put(8'hC0, 1'b1, "R9 address ack");
        put(8'h15, 1'b1, "R4 command ack");
        bus_start();
        put(8'hC1, 1'b1, "R8 read address ack");
        read_byte(1'b0, got); chk("R4 wrap read ptr5", got, 8'h05);
        read_byte(1'b0, got); chk("R4 wrap read ptr6", got, 8'hFA);
        read_byte(1'b0, got); chk("R4 wrap read ptr7 alias", got, 8'hFA);
        read_byte(1'b1, got); chk("R4 R6 wrap read ptr0 pins", got, 8'h3C);
        w(Q);
        chk("R7 released after NACK", {7'd0, sda_oe}, 8'h00);
        bus_stop();

        // R4 without stepping: two bytes land on the same register
        bus_start();
        put(8'hC0, 1'b1, "R9 address ack");
        put(8'h02, 1'b1, "R4 command ack");
        put(8'h11, 1'b1, "R4 data ack");
        put(8'h22, 1'b1, "R4 data ack");
        bus_stop();
        chk("R4 no-step duty0", duty0, 8'h22);
        chk("R4 no-step rate1 untouched", rate1, 8'h03);

        // R2 foreign address ignored
        bus_start();
        put(8'hC2, 1'b0, "R2 foreign address nack");
        put(8'h01, 1'b0, "R2 foreign command nack");
        put(8'hEE, 1'b0, "R2 foreign data nack");
        bus_stop();
        chk("R2 rate0 untouched", rate0, 8'h01);

        // R2 strap pins move the address
        dev_sel = 3'd5;
        bus_start();
        put(8'hC0, 1'b0, "R2 old address now nack");
        bus_stop();
        bus_start();
        put(8'hCA, 1'b1, "R2 strapped address ack");
        put(8'h01, 1'b1, "R2 command ack");
        put(8'h77, 1'b1, "R2 data ack");
        bus_stop();
        chk("R2 strapped write rate0", rate0, 8'h77);

        // R1 reset again after activity
        rst = 1'b1; w(3);
        rst = 1'b0; w(3);
        chk("R1 duty1 after reset", duty1, 8'h80);
        chk("R1 rate0 after reset", rate0, 8'h00);
        chk("R1 sel_hi after reset", sel_hi, 8'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule